// File: doc/BRIEF.md
# Vectored Interrupt Pending and Mask Unit

This block tracks sixteen interrupt sources. Each source has an enable bit, a pending bit, an in-service bit and a mask bit. An event on an enabled source sets its pending bit. The unit raises a request when the highest-numbered pending source that is also masked-in outranks every source currently in service. A processor answers the request with an acknowledge, and the unit hands back a vector built from a programmable base and the number of the winning source.

Software reaches the state through a byte-wide write port. Every 16-bit register is split into a high half and a low half, each at its own address. Pending and in-service halves can only be cleared by software, never set. A control byte holds the vector base and selects one of two end-of-interrupt styles:
- In software style, an acknowledged source is held in service until software clears it. Sources of equal or lower rank are blocked meanwhile.
- In automatic style, nothing is ever held in service.

Top module: `intc_vector_unit`

## Requirements
- R1: After reset every enable, pending, in-service and mask bit is 0, the control byte is 0 (automatic style, base 0) and `irq_req` is low.
- R2: Write addresses: 0/1 enable high/low byte, 2/3 pending high/low, 4/5 in-service high/low, 6/7 mask high/low, 8 control byte. The high byte covers sources 15..8 and the low byte covers sources 7..0. Any other address has no effect.
- R3: An event on a source whose enable bit is 0 never sets that source's pending bit.
- R4: Writing an enable byte replaces that half and clears every pending bit whose enable bit is now 0.
- R5: Writing a pending or in-service byte ANDs the data into that half: a 0 clears the bit and a 1 leaves it as it was.
- R6: A pending bit whose mask bit is 0 does not request. Writing a mask byte replaces that half and clears every in-service bit whose mask bit is now 0.
- R7: Control byte: bits 7:4 are the vector base and bit 3 selects software style (1) or automatic style (0). Writing it with bit 3 = 0 clears all in-service bits.
- R8: Source 15 ranks highest and source 0 lowest. `ack_vector` is {base, 4-bit number of the highest pending masked-in source}.
- R9: `irq_req` is high exactly when some pending masked-in source ranks above every in-service source, or no source is in service.
- R10: An acknowledge while `irq_req` is high clears the winner's pending bit and, in software style only, sets its in-service bit. An acknowledge while `irq_req` is low changes nothing.
- R11: An enabled source event in the same cycle as a clear of its pending bit (by write or acknowledge) leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 16 | Per-source event, sampled each cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| ack | input | 1 | Interrupt acknowledge |
| irq_req | output | 1 | Interrupt request |
| ack_vector | output | 8 | Vector of the current winning source |

## Verification
Some invariants are checked by assertions on every cycle:
- A pending bit never appears while its enable bit is 0.
- An in-service bit never survives without its mask bit.
- Nothing is held in service in automatic style.
- A request always has a masked-in pending source behind it.
- An acknowledge updates the winner's pending and in-service bits as specified.

The bench scenarios cover the behaviours that span several steps:
- The full nesting matrix, with each source in service against each new source.
- Priority ordering under multi-bit patterns.
- Pruning by enable and mask writes, which shows up later as a request that never comes back.
- The same-cycle race between a source event and a clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned SOFT_EOI_BIT = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EN_HI  = 4'd0,
    SEL_EN_LO  = 4'd1,
    SEL_PND_HI = 4'd2,
    SEL_PND_LO = 4'd3,
    SEL_ISV_HI = 4'd4,
    SEL_ISV_LO = 4'd5,
    SEL_MSK_HI = 4'd6,
    SEL_MSK_LO = 4'd7,
    SEL_CTL    = 4'd8
  } reg_sel_e;
endpackage

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int unsigned W = 16,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Highest set bit wins: later iterations override earlier ones.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned NSRC = 2 * HALF_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [HALF_W-1:0]              wr_data,
  output logic [NSRC-1:0]                en_q,
  output logic [NSRC-1:0]                en_nx,
  output logic [NSRC-1:0]                msk_q,
  output logic [NSRC-1:0]                msk_nx,
  output logic [HALF_W-1:SOFT_EOI_BIT]   ctl_q,
  output logic                           auto_clr
);
  logic [HALF_W-1:SOFT_EOI_BIT] ctl_nx;

  always_comb begin
    en_nx    = en_q;
    msk_nx   = msk_q;
    ctl_nx   = ctl_q;
    auto_clr = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        SEL_EN_HI:  en_nx[HALF_W +: HALF_W]  = wr_data;
        SEL_EN_LO:  en_nx[0 +: HALF_W]       = wr_data;
        SEL_MSK_HI: msk_nx[HALF_W +: HALF_W] = wr_data;
        SEL_MSK_LO: msk_nx[0 +: HALF_W]      = wr_data;
        SEL_CTL: begin
          ctl_nx   = wr_data[HALF_W-1:SOFT_EOI_BIT];
          auto_clr = !wr_data[SOFT_EOI_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      en_q  <= en_nx;
      msk_q <= msk_nx;
      ctl_q <= ctl_nx;
    end
  end
endmodule

// File: rtl/intc_src_state.sv
module intc_src_state
  import intc_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned NSRC = 2 * HALF_W,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic [NSRC-1:0]   en_nx,
  input  logic [NSRC-1:0]   msk_nx,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              ack_take,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              soft_eoi,
  input  logic              auto_clr,
  output logic [NSRC-1:0]   pnd_q,
  output logic [NSRC-1:0]   isv_q
);
  logic [NSRC-1:0] pnd_nx;
  logic [NSRC-1:0] isv_nx;

  always_comb begin
    pnd_nx = pnd_q;
    isv_nx = isv_q;
    if (ack_take) begin
      pnd_nx[win_idx] = 1'b0;
      if (soft_eoi) isv_nx[win_idx] = 1'b1;
    end
    if (wr_en) begin
      case (wr_addr)
        SEL_PND_HI: pnd_nx[HALF_W +: HALF_W] = pnd_nx[HALF_W +: HALF_W] & wr_data;
        SEL_PND_LO: pnd_nx[0 +: HALF_W]      = pnd_nx[0 +: HALF_W] & wr_data;
        SEL_ISV_HI: isv_nx[HALF_W +: HALF_W] = isv_nx[HALF_W +: HALF_W] & wr_data;
        SEL_ISV_LO: isv_nx[0 +: HALF_W]      = isv_nx[0 +: HALF_W] & wr_data;
        default: ;
      endcase
    end
    // Enable pruning, then new events (which win over clears).
    pnd_nx = (pnd_nx | src_evt) & en_nx;
    isv_nx = auto_clr ? '0 : (isv_nx & msk_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnd_q <= '0;
      isv_q <= '0;
    end else begin
      pnd_q <= pnd_nx;
      isv_q <= isv_nx;
    end
  end
endmodule

// File: rtl/intc_vector_unit.sv
module intc_vector_unit
  import intc_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned NSRC = 2 * HALF_W,
  parameter int unsigned IDX_W = $clog2(NSRC),
  parameter int unsigned VEC_W = (HALF_W - 4) + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  ack_vector
);
  logic [NSRC-1:0]              en_q, en_nx, msk_q, msk_nx;
  logic [NSRC-1:0]              pnd_q, isv_q;
  logic [HALF_W-1:SOFT_EOI_BIT] ctl_q;
  logic                         auto_clr;
  logic                         cand_any, isv_any;
  logic [IDX_W-1:0]             cand_idx, isv_idx;
  logic                         ack_take;
  logic                         soft_eoi;

  assign soft_eoi = ctl_q[SOFT_EOI_BIT];

  intc_cfg_regs #(.HALF_W(HALF_W), .NSRC(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_q(en_q), .en_nx(en_nx), .msk_q(msk_q), .msk_nx(msk_nx),
    .ctl_q(ctl_q), .auto_clr(auto_clr)
  );

  intc_src_state #(.HALF_W(HALF_W), .NSRC(NSRC), .IDX_W(IDX_W)) u_state (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .en_nx(en_nx), .msk_nx(msk_nx),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_take(ack_take), .win_idx(cand_idx), .soft_eoi(soft_eoi), .auto_clr(auto_clr),
    .pnd_q(pnd_q), .isv_q(isv_q)
  );

  intc_prio_enc #(.W(NSRC), .IDX_W(IDX_W)) u_cand_enc (
    .vec(pnd_q & msk_q), .any(cand_any), .idx(cand_idx)
  );

  intc_prio_enc #(.W(NSRC), .IDX_W(IDX_W)) u_isv_enc (
    .vec(isv_q), .any(isv_any), .idx(isv_idx)
  );

  assign irq_req    = cand_any && (!isv_any || (cand_idx > isv_idx));
  assign ack_take   = ack && irq_req;
  assign ack_vector = {ctl_q[HALF_W-1:4], cand_idx};

  a_r3_no_latch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((pnd_q & ~$past(pnd_q)) & ~en_q) == '0);

  a_r6_service_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (isv_q & ~msk_q) == '0);

  a_r7_auto_holds_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_eoi |-> (isv_q == '0));

  a_r9_req_has_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pnd_q & msk_q) != '0));

  a_r10_ack_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && soft_eoi && !wr_en) |=> isv_q[$past(cand_idx)]);

  a_r10_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !wr_en && !src_evt[cand_idx]) |=> !pnd_q[$past(cand_idx)]);
endmodule

// File: tb/tb_intc_vector_unit.sv
module tb_intc_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_evt;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        ack;
  logic        irq_req;
  logic [7:0]  ack_vector;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  intc_vector_unit dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack(ack), .irq_req(irq_req), .ack_vector(ack_vector)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_irq(input string rq, input logic exp_irq, input logic [7:0] exp_vec);
    chk(rq, {31'd0, irq_req}, {31'd0, exp_irq});
    if (exp_irq) chk(rq, {24'd0, ack_vector}, {24'd0, exp_vec});
  endtask

  task automatic cyc(input logic [15:0] s, input logic a, input logic w,
                     input logic [3:0] ad, input logic [7:0] d);
    @(negedge clk);
    src_evt = s; ack = a; wr_en = w; wr_addr = ad; wr_data = d;
    @(negedge clk);
    src_evt = '0; ack = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wrr(input logic [3:0] ad, input logic [7:0] d);
    cyc(16'h0, 1'b0, 1'b1, ad, d);
  endtask

  task automatic fire(input logic [15:0] s);
    cyc(s, 1'b0, 1'b0, 4'd0, 8'd0);
  endtask

  task automatic do_ack();
    cyc(16'h0, 1'b1, 1'b0, 4'd0, 8'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] pats [5];
    logic [15:0] rem;
    int          top;
    pats = '{16'hFFFF, 16'h8001, 16'h1234, 16'h0F00, 16'hA5A5};
    rst_n = 1'b0; src_evt = '0; ack = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset irq", {31'd0, irq_req}, 32'd0);

    // R3: events while disabled leave nothing behind
    fire(16'hFFFF);
    wrr(4'd0, 8'hFF); wrr(4'd1, 8'hFF); wrr(4'd6, 8'hFF); wrr(4'd7, 8'hFF);
    chk("R3 disabled events not latched", {31'd0, irq_req}, 32'd0);

    // R8/R9/R10 nesting matrix in software style, base A (R2 halves)
    wrr(4'd8, 8'hA8);
    for (int i = 0; i < 16; i++) begin
      fire(16'h1 << i);
      chk_irq("R8 R2 single source", 1'b1, {4'hA, 4'(i)});
      do_ack();
      chk_irq("R10 ack blocks own rank", 1'b0, 8'h0);
      for (int j = 0; j < 16; j++) begin
        fire(16'h1 << j);
        chk_irq("R9 nesting", (j > i), {4'hA, 4'(j)});
        wrr((j >= 8) ? 4'd2 : 4'd3, ~(8'h1 << (j % 8)));
        chk_irq("R5 pending and-clear", 1'b0, 8'h0);
      end
      wrr((i >= 8) ? 4'd4 : 4'd5, ~(8'h1 << (i % 8)));
      chk_irq("R5 service and-clear", 1'b0, 8'h0);
    end

    // R8/R10 automatic style: descending order drain
    wrr(4'd8, 8'hA0);
    foreach (pats[k]) begin
      fire(pats[k]);
      rem = pats[k];
      while (rem != 16'h0) begin
        top = 0;
        for (int b = 0; b < 16; b++) if (rem[b]) top = b;
        chk_irq("R8 priority order", 1'b1, {4'hA, 4'(top)});
        do_ack();
        rem[top] = 1'b0;
      end
      chk_irq("R10 auto drain empty", 1'b0, 8'h0);
    end

    // R4 enable write prunes pending
    fire(16'h0100);
    chk_irq("R4 setup", 1'b1, 8'hA8);
    wrr(4'd0, 8'h00);
    chk_irq("R4 pruned", 1'b0, 8'h0);
    wrr(4'd0, 8'hFF);
    chk_irq("R4 stays pruned", 1'b0, 8'h0);

    // R6 mask gates request, mask write prunes service
    wrr(4'd7, 8'h00);
    fire(16'h0008);
    chk_irq("R6 masked out", 1'b0, 8'h0);
    wrr(4'd7, 8'hFF);
    chk_irq("R6 unmasked", 1'b1, 8'hA3);
    do_ack();
    wrr(4'd8, 8'hA8);
    fire(16'h0400);
    do_ack();
    fire(16'h0020);
    chk_irq("R9 blocked by service", 1'b0, 8'h0);
    wrr(4'd6, 8'h00);
    chk_irq("R6 service pruned", 1'b1, 8'hA5);
    do_ack();
    wrr(4'd6, 8'hFF);
    wrr(4'd5, 8'hDF);
    chk_irq("R5 cleanup", 1'b0, 8'h0);

    // R7 switching to automatic style clears service; R10 ignored ack
    fire(16'h1000);
    do_ack();
    fire(16'h0004);
    chk_irq("R9 blocked", 1'b0, 8'h0);
    do_ack();
    wrr(4'd8, 8'h30);
    chk_irq("R7 auto clears service", 1'b1, 8'h32);
    chk_irq("R10 ignored ack kept pending", 1'b1, 8'h32);
    do_ack();
    chk_irq("R10 auto ack", 1'b0, 8'h0);

    // R5 ones leave pending untouched
    wrr(4'd6, 8'h00);
    fire(16'h0200);
    wrr(4'd2, 8'hFF);
    wrr(4'd6, 8'hFF);
    chk_irq("R5 ones keep bit", 1'b1, 8'h39);
    do_ack();

    // R2 unused address has no effect
    wrr(4'd12, 8'h00);
    fire(16'h0001);
    chk_irq("R2 unused address", 1'b1, 8'h30);
    do_ack();

    // R11 same-cycle event beats clears
    cyc(16'h0080, 1'b0, 1'b1, 4'd3, 8'h00);
    chk_irq("R11 event beats write clear", 1'b1, 8'h37);
    cyc(16'h0080, 1'b1, 1'b0, 4'd0, 8'h00);
    chk_irq("R11 event beats ack clear", 1'b1, 8'h37);
    do_ack();
    chk_irq("R10 final drain", 1'b0, 8'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule